// File: doc/BRIEF.md
# Quad Low-Side Switch Control and Diagnosis

This block is the digital core of a four-channel low-side output switch. It turns four channel requests into four gate-drive enables. A global enable can override every request, and a program bit selects whether the requests are active-high or active-low. An input that is marked floating never switches its channel on.

The block also watches two comparator results for each channel. The first is an open-load or short-to-ground flag, which counts only while the channel is commanded off. The second is a temperature code. When a channel is commanded on and its temperature reaches the shutdown threshold, a per-channel thermal latch switches that channel off. The channel restarts by itself once the temperature has fallen by the hysteresis. Under a steady overload this gives an on/off pulsing pattern.

Each qualified condition must persist for a number of clock cycles before it is reported. The filtered results are merged into one fault output. With the block enabled and no fault present, the fault output rests at the level of the program bit, and a fault drives it to the opposite level. In standby the fault output reads high.

Top module: `quad_lsd_ctrl`

## Requirements
- R1: While `en` is 0, every bit of `gate_on` is 0 and `fault` is 1, for either value of `pol`.
- R2: With `en` at 1, a channel is requested on when `ch_in` equals `pol` (`pol`=1: input 1 means on; `pol`=0: input 0 means on). Its `gate_on` bit follows the request in the same cycle unless its thermal latch is set.
- R3: A channel whose `ch_float` bit is 1 has `gate_on` 0 for both values of `pol` and of its input.
- R4: With `en` at 1, `fault` equals `pol` when no channel holds a filtered fault, and equals the inverse of `pol` when at least one channel does.
- R5: An `ol_flag` bit is qualified only while `en` is 1 and that channel is not requested on. The flag never changes `gate_on`.
- R6: If a channel is requested on and its temperature code (bits `i*TW +: TW` of `temp_code`) is at or above `T_SD`, its thermal latch sets at the next clock edge. That channel's `gate_on` then goes to 0 while the other channels are unaffected. A latched channel that is still requested on is a qualified over-temperature condition.
- R7: The thermal latch clears at the clock edge after the temperature code is at or below `T_SD-T_HYS`, and holds at any code between the two thresholds.
- R8: A qualified condition is reported on `fault` only after `DLY` consecutive clock edges. Any cycle without the condition restarts the count, and `fault` returns to its idle level one edge after the condition ends.
- R9: After reset, all thermal latches and delay counters are clear, so `gate_on` follows the requests and no fault is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for fault filtering and thermal latches |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Global enable; 0 is standby |
| pol | input | 1 | Request polarity and fault idle level |
| ch_in | input | NCH | Channel requests |
| ch_float | input | NCH | Per-channel unconnected-input indication |
| temp_code | input | NCH*TW | Packed unsigned temperature codes |
| ol_flag | input | NCH | Open-load / short-to-ground comparator flags |
| gate_on | output | NCH | Gate-drive enables |
| fault | output | 1 | Shared fault flag |

## Verification
In a single cycle, one channel can cross the shutdown threshold and lose its gate while another channel's open-load count reaches its delay limit. These are two different fault origins that meet on the single fault output. Random patterns hold temperatures near the thresholds and raise open-load flags on idle channels for stretches longer than the delay. Directed steps also place the latch edge and the count boundary on known cycles. Each cycle is judged against a bench model of the latches and counters: every channel's gate must be correct, and the shared flag must be inverted exactly when some channel's count is complete.

// File: rtl/quad_lsd_ctrl.sv
module quad_lsd_ctrl #(
  parameter int NCH   = 4,
  parameter int TW    = 8,
  parameter int T_SD  = 170,
  parameter int T_HYS = 10,
  parameter int DLY   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pol,
  input  logic [NCH-1:0]   ch_in,
  input  logic [NCH-1:0]   ch_float,
  input  logic [NCH*TW-1:0] temp_code,
  input  logic [NCH-1:0]   ol_flag,
  output logic [NCH-1:0]   gate_on,
  output logic             fault
);
  localparam int CW = $clog2(DLY + 1);
  localparam logic [TW-1:0] SD_LVL = TW'(T_SD);
  localparam logic [TW-1:0] RS_LVL = TW'(T_SD - T_HYS);
  localparam logic [CW-1:0] CMAX   = CW'(DLY);

  logic [NCH-1:0] req, hot, filt;

  assign req = {NCH{en}} & ~ch_float & (pol ? ch_in : ~ch_in);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [TW-1:0] t;
    logic [CW-1:0] cnt;
    logic          qual;
    assign t    = temp_code[i*TW +: TW];
    assign qual = (en & ~req[i] & ol_flag[i]) | (req[i] & hot[i]);

    always_ff @(posedge clk) begin
      if (!rst_n)                       hot[i] <= 1'b0;
      else if (req[i] && t >= SD_LVL)   hot[i] <= 1'b1;
      else if (t <= RS_LVL)             hot[i] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n || !qual) cnt <= '0;
      else if (cnt != CMAX) cnt <= cnt + 1'b1;
    end

    assign filt[i] = (cnt == CMAX);
  end

  assign gate_on = req & ~hot;
  assign fault   = ~en | ((|filt) ^ pol);
endmodule

module quad_lsd_ctrl_chk #(
  parameter int NCH   = 4,
  parameter int TW    = 8,
  parameter int T_SD  = 170,
  parameter int T_HYS = 10,
  parameter int DLY   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              pol,
  input logic [NCH-1:0]    ch_in,
  input logic [NCH-1:0]    ch_float,
  input logic [NCH*TW-1:0] temp_code,
  input logic [NCH-1:0]    ol_flag,
  input logic [NCH-1:0]    gate_on,
  input logic              fault
);
  // R1
  standby_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (gate_on == '0) && fault);

  // R4
  fault_needs_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (fault != pol)) |-> $past(en));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R2
    gate_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate_on[i] |-> en && (ch_in[i] == pol));
    // R3
    float_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_float[i] |-> !gate_on[i]);
    // R6
    thermal_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_on[i] && (temp_code[i*TW +: TW] >= TW'(T_SD))) |=> !gate_on[i]);
  end
endmodule

bind quad_lsd_ctrl quad_lsd_ctrl_chk #(
  .NCH(NCH), .TW(TW), .T_SD(T_SD), .T_HYS(T_HYS), .DLY(DLY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pol(pol), .ch_in(ch_in),
  .ch_float(ch_float), .temp_code(temp_code), .ol_flag(ol_flag),
  .gate_on(gate_on), .fault(fault)
);

// File: tb/quad_lsd_ctrl_bench.sv
module quad_lsd_ctrl_bench;
  localparam int NCH = 4, TW = 8, T_SD = 170, T_HYS = 10, DLY = 6;
  localparam int RS = T_SD - T_HYS;

  logic clk = 1'b0;
  logic rst_n = 1'b0, en = 1'b0, pol = 1'b0;
  logic [NCH-1:0] ch_in = '0, ch_float = '0, ol_flag = '0;
  logic [TW-1:0] tmp [NCH];
  logic [NCH*TW-1:0] temp_code;
  logic [NCH-1:0] gate_on;
  logic fault;
  int errs = 0, checks = 0;
  bit live = 1'b0;

  always #2 clk = ~clk;

  for (genvar i = 0; i < NCH; i++) begin : g_pk
    assign temp_code[i*TW +: TW] = tmp[i];
  end

  quad_lsd_ctrl #(.NCH(NCH), .TW(TW), .T_SD(T_SD), .T_HYS(T_HYS), .DLY(DLY)) u_quad_lsd_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .pol(pol), .ch_in(ch_in), .ch_float(ch_float),
    .temp_code(temp_code), .ol_flag(ol_flag), .gate_on(gate_on), .fault(fault));

  logic [NCH-1:0] m_hot;
  int m_cnt [NCH];

  function automatic logic [NCH-1:0] want_req();
    return {NCH{en}} & ~ch_float & (pol ? ch_in : ~ch_in);
  endfunction

  function automatic logic want_fault();
    logic any = 1'b0;
    for (int i = 0; i < NCH; i++) if (m_cnt[i] >= DLY) any = 1'b1;
    return !en ? 1'b1 : (any ? ~pol : pol);
  endfunction

  always @(posedge clk) begin
    logic [NCH-1:0] r;
    r = want_req();
    for (int i = 0; i < NCH; i++) begin
      if (!rst_n) begin
        m_hot[i] <= 1'b0; m_cnt[i] <= 0;
      end else begin
        if (r[i] && tmp[i] >= T_SD) m_hot[i] <= 1'b1;
        else if (tmp[i] <= RS) m_hot[i] <= 1'b0;
        if ((en && !r[i] && ol_flag[i]) || (r[i] && m_hot[i]))
          m_cnt[i] <= (m_cnt[i] < DLY) ? m_cnt[i] + 1 : DLY;
        else m_cnt[i] <= 0;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (live) begin
    chk("R2 R4 R6 R7 R8 model gate", 32'(gate_on), 32'(want_req() & ~m_hot));
    chk("R1 R4 R5 R8 model fault", 32'(fault), 32'(want_fault()));
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_all_tmp(logic [TW-1:0] v);
    for (int i = 0; i < NCH; i++) tmp[i] = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7731));
    set_all_tmp(8'd25);
    tick(3);
    chk("R9 reset gate", 32'(gate_on), 0);
    chk("R9 reset fault standby", 32'(fault), 1);
    rst_n = 1'b1; live = 1'b1;
    tick(1);
    // R1: standby for both polarities
    en = 0; pol = 1; ch_in = 4'hF; tick(2);
    chk("R1 gate pol1", 32'(gate_on), 0); chk("R1 fault pol1", 32'(fault), 1);
    pol = 0; ch_in = 4'h0; tick(2);
    chk("R1 gate pol0", 32'(gate_on), 0); chk("R1 fault pol0", 32'(fault), 1);
    // R2 / R4: polarity of requests and fault idle level
    en = 1; pol = 1; ch_in = 4'b0101; tick(1);
    chk("R2 active-high", 32'(gate_on), 32'h5); chk("R4 idle pol1", 32'(fault), 1);
    pol = 0; tick(1);
    chk("R2 active-low", 32'(gate_on), 32'hA); chk("R4 idle pol0", 32'(fault), 0);
    // R3: floating inputs off
    ch_float = 4'hF; ch_in = 4'h0; tick(1);
    chk("R3 float pol0", 32'(gate_on), 0);
    pol = 1; ch_in = 4'hF; tick(1);
    chk("R3 float pol1", 32'(gate_on), 0);
    ch_float = 4'h0;
    // R5 / R8: open load on off channel 1 and on-channel 0
    ch_in = 4'b0001; ol_flag = 4'b0011; tick(DLY - 1);
    chk("R5 gate unaffected", 32'(gate_on), 32'h1);
    chk("R8 not yet", 32'(fault), 1);
    tick(1);
    chk("R8 reported at DLY", 32'(fault), 0);
    ol_flag = 4'b0001; tick(1);
    chk("R8 clears after one edge", 32'(fault), 1);
    ol_flag = 4'b0011; tick(DLY - 2);
    ol_flag = 4'b0001; tick(1);
    ol_flag = 4'b0011; tick(DLY - 1);
    chk("R8 break restarts count", 32'(fault), 1);
    ol_flag = 4'b0001; tick(3 * DLY);
    chk("R5 on-channel flag ignored", 32'(fault), 1);
    ol_flag = 4'h0;
    // R6 / R7: thermal latch on channel 2
    ch_in = 4'hF; tmp[2] = 8'(T_SD - 1); tick(2);
    chk("R6 below threshold", 32'(gate_on), 32'hF);
    tmp[2] = 8'(T_SD); tick(1);
    chk("R6 only ch2 off", 32'(gate_on), 32'hB);
    tmp[2] = 8'(RS + 1); tick(DLY - 1);
    chk("R7 hold in hysteresis", 32'(gate_on), 32'hB);
    chk("R6 R8 ot not yet", 32'(fault), 1);
    tick(1);
    chk("R6 R8 ot reported", 32'(fault), 0);
    tmp[2] = 8'(RS); tick(1);
    chk("R7 restart", 32'(gate_on), 32'hF);
    set_all_tmp(8'd25);
    // random mix
    for (int n = 0; n < 400; n++) begin
      en = ($urandom % 8) != 0;
      pol = $urandom;
      ch_in = 4'($urandom);
      ch_float = (($urandom % 5) == 0) ? 4'($urandom) : 4'h0;
      ol_flag = 4'($urandom);
      for (int i = 0; i < NCH; i++)
        if ($urandom % 3 != 0) tmp[i] = 8'(RS - 3 + ($urandom % 18));
      tick(1 + ($urandom % (3 * DLY)));
    end
    // directed coincidence: ch0 thermal cut and ch3 open-load maturing together
    en = 1; pol = 1; set_all_tmp(8'd25); ch_float = 0; ol_flag = 0; ch_in = 4'b0001;
    tick(DLY + 2);
    ol_flag = 4'b1000; tick(DLY - 1);
    tmp[0] = 8'(T_SD); tick(1);
    chk("R6 coincident cut", 32'(gate_on), 0);
    chk("R8 coincident report", 32'(fault), 0);
    live = 1'b0;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule